// File: doc/BRIEF.md
# Control Cell Mailbox

This block is the host-facing mailbox through which a microprocessor exchanges control cells with a cell bus. The host uses a byte-wide register bus to reach three regions: a control/status register, a transmit window and a receive window.

To send a cell, the host fills the transmit window, one byte per address, and then sets a request bit. The block streams the stored bytes to the bus transmitter over a valid/ready handshake. It clears the request bit on its own once the final byte has been accepted.

On the receive side, the upstream header filter hands the block accepted control cells as a byte stream. These cells are queued in a small FIFO of whole cells. The host sees only the oldest cell, through the receive window, and discards it by setting a pop bit. A cell that arrives while the queue is full is lost, and a sticky flag records the loss.

Top module: `ctl_mbox`

## Requirements
- R1: After reset the control/status register (offset 10h) reads 00h and `cout_valid` is low.
- R2: Host writes to offsets A0h..D7h load transmit byte k = offset - A0h. After transmission starts, the 56 bytes leave on `cout_data` in ascending k. `cout_last` is high with byte 55 only.
- R3: While `cout_valid` is high and `cout_ready` is low, `cout_valid` stays high and `cout_data`/`cout_last` hold their values on the next cycle.
- R4: Writing control/status bit 0 = 1 starts transmission. Bit 0 then reads 1 until the clock edge that accepts byte 55, and reads 0 from the next cycle on.
- R5: Writes to the transmit window while bit 0 reads 1 do not change the stored cell. A later request with no reload sends the same bytes again.
- R6: Each run of 52 bytes on `cin_valid`/`cin_data` forms one cell. The oldest queued cell is readable as byte k at offset 60h + k, for k = 0..51.
- R7: Writing control/status bit 1 = 1 removes the oldest cell, so the next cell in arrival order becomes readable. With an empty queue the write has no effect.
- R8: The queue holds 4 cells. A cell whose first byte arrives while 4 cells are queued is discarded entirely, and bit 2 of control/status goes to 1. Bit 2 stays 1 until the host writes 1 to bit 2.
- R9: Control/status bit 1 reads 1 exactly when the queue is non-empty. With an empty queue, offsets 60h..93h read 00h. Offsets outside the three regions also read 00h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| arst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_we | input | 1 | Host write strobe for `host_addr` |
| host_addr | input | 8 | Host byte offset for reads and writes |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for `host_addr`, combinational |
| cin_valid | input | 1 | Receive byte valid from the header filter |
| cin_data | input | 8 | Receive byte |
| cout_valid | output | 1 | Transmit byte valid |
| cout_ready | input | 1 | Transmitter accepts the byte |
| cout_data | output | 8 | Transmit byte |
| cout_last | output | 1 | Marks the final byte of the cell |

## Verification
The bench builds the block with its default parameters: 56-byte transmit cells, 52-byte receive cells and a 4-cell queue. Because the queue is shallow, filling it and overflowing it takes only five cells. That keeps the dropped-cell path, the sticky flag and a full drain in FIFO order within a short run. The full 56-byte cell length exercises the last-byte edge of the busy bit under randomly stalled `cout_ready`.

// File: rtl/ctl_mbox_pkg.sv
package ctl_mbox_pkg;

  // control/status bit positions
  localparam int unsigned REQ_BIT = 0;
  localparam int unsigned POP_BIT = 1;
  localparam int unsigned OVF_BIT = 2;

  // host address regions
  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_CTRL,
    WIN_TX,
    WIN_RX
  } win_e;

endpackage

// File: rtl/mbox_rst_sync.sv
module mbox_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_n_o = sync_q[1];

endmodule

// File: rtl/mbox_tx_buf.sv
module mbox_tx_buf #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 56
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_en,
  input  logic [$clog2(CELL_BYTES)-1:0]    wr_idx,
  input  logic [DATA_W-1:0]                wr_data,
  input  logic                             start,
  output logic                             busy,
  output logic                             out_valid,
  input  logic                             out_ready,
  output logic [DATA_W-1:0]                out_data,
  output logic                             out_last
);

  localparam int unsigned IDX_W = $clog2(CELL_BYTES);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(CELL_BYTES - 1);

  logic [DATA_W-1:0] mem [CELL_BYTES];
  logic              busy_q, busy_d;
  logic [IDX_W-1:0]  idx_q, idx_d;
  logic              fire, at_last, mem_we;

  assign at_last = (idx_q == LAST_IDX);
  assign fire    = busy_q && out_ready;
  // loading is locked while a request is pending
  assign mem_we  = wr_en && !busy_q;

  always_comb begin
    busy_d = busy_q;
    idx_d  = idx_q;
    if (busy_q) begin
      if (fire) begin
        if (at_last) begin
          busy_d = 1'b0;
          idx_d  = '0;
        end else begin
          idx_d  = idx_q + 1'b1;
        end
      end
    end else if (start) begin
      busy_d = 1'b1;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else begin
      busy_q <= busy_d;
      idx_q  <= idx_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[wr_idx] <= wr_data;
    end
  end

  assign busy      = busy_q;
  assign out_valid = busy_q;
  assign out_data  = busy_q ? mem[idx_q] : '0;
  assign out_last  = busy_q && at_last;

endmodule

// File: rtl/mbox_rx_fifo.sv
module mbox_rx_fifo #(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 52,
  parameter int unsigned CELLS      = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [DATA_W-1:0]             in_data,
  input  logic                          pop,
  input  logic [$clog2(CELL_BYTES)-1:0] rd_idx,
  output logic [DATA_W-1:0]             rd_data,
  output logic                          not_empty,
  output logic                          drop
);

  localparam int unsigned BYTE_W = $clog2(CELL_BYTES);
  localparam int unsigned SLOT_W = (CELLS > 1) ? $clog2(CELLS) : 1;
  localparam int unsigned CNT_W  = $clog2(CELLS + 1);
  localparam int unsigned MEM_N  = CELLS * CELL_BYTES;
  localparam int unsigned MEM_W  = $clog2(MEM_N);
  localparam logic [BYTE_W-1:0] LAST_BYTE = BYTE_W'(CELL_BYTES - 1);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(CELLS - 1);
  localparam logic [CNT_W-1:0]  FULL_CNT  = CNT_W'(CELLS);

  logic [DATA_W-1:0] mem [MEM_N];

  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [SLOT_W-1:0] wslot_q, wslot_d;
  logic [SLOT_W-1:0] rslot_q, rslot_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              skip_q, skip_d;

  logic              first, full, keep, cell_end, commit, do_pop, mem_we;
  logic [MEM_W-1:0]  waddr, raddr;

  assign first    = (byte_q == '0);
  assign full     = (cnt_q == FULL_CNT);
  // keep decision is made on the first byte and held for the rest of the cell
  assign keep     = first ? !full : !skip_q;
  assign cell_end = in_valid && (byte_q == LAST_BYTE);
  assign commit   = cell_end && keep;
  assign do_pop   = pop && (cnt_q != '0);
  assign mem_we   = in_valid && keep;
  assign drop     = in_valid && first && full;

  assign waddr = MEM_W'(wslot_q) * MEM_W'(CELL_BYTES) + MEM_W'(byte_q);
  assign raddr = MEM_W'(rslot_q) * MEM_W'(CELL_BYTES) + MEM_W'(rd_idx);

  always_comb begin
    byte_d  = byte_q;
    skip_d  = skip_q;
    wslot_d = wslot_q;
    rslot_d = rslot_q;
    cnt_d   = cnt_q;
    if (in_valid) begin
      byte_d = cell_end ? '0 : byte_q + 1'b1;
      if (first) begin
        skip_d = full;
      end
    end
    if (commit) begin
      wslot_d = (wslot_q == LAST_SLOT) ? '0 : wslot_q + 1'b1;
    end
    if (do_pop) begin
      rslot_d = (rslot_q == LAST_SLOT) ? '0 : rslot_q + 1'b1;
    end
    case ({commit, do_pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q  <= '0;
      skip_q  <= 1'b0;
      wslot_q <= '0;
      rslot_q <= '0;
      cnt_q   <= '0;
    end else begin
      byte_q  <= byte_d;
      skip_q  <= skip_d;
      wslot_q <= wslot_d;
      rslot_q <= rslot_d;
      cnt_q   <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (mem_we) begin
      mem[waddr] <= in_data;
    end
  end

  assign not_empty = (cnt_q != '0);
  assign rd_data   = (not_empty && (rd_idx <= LAST_BYTE)) ? mem[raddr] : '0;

endmodule

// File: rtl/ctl_mbox.sv
module ctl_mbox
  import ctl_mbox_pkg::*;
#(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned TX_BYTES  = 56,
  parameter int unsigned RX_BYTES  = 52,
  parameter int unsigned RX_CELLS  = 4,
  parameter int unsigned CTRL_ADDR = 'h10,
  parameter int unsigned TX_BASE   = 'hA0,
  parameter int unsigned RX_BASE   = 'h60
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              host_we,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  input  logic              cin_valid,
  input  logic [DATA_W-1:0] cin_data,
  output logic              cout_valid,
  input  logic              cout_ready,
  output logic [DATA_W-1:0] cout_data,
  output logic              cout_last
);

  localparam int unsigned TX_IDX_W = $clog2(TX_BYTES);
  localparam int unsigned RX_IDX_W = $clog2(RX_BYTES);

  logic              rst_n;
  win_e              win;
  logic [ADDR_W-1:0] tx_off, rx_off;
  logic              tx_wr, ctrl_wr, tx_start, rx_pop, ovf_clr;
  logic              tx_busy, rx_not_empty, rx_drop;
  logic [DATA_W-1:0] rx_rd_data;
  logic              ovf_q, ovf_d;

  mbox_rst_sync u_rst (
    .clk     (clk),
    .arst_n  (arst_n),
    .rst_n_o (rst_n)
  );

  // address decode
  assign tx_off = host_addr - ADDR_W'(TX_BASE);
  assign rx_off = host_addr - ADDR_W'(RX_BASE);

  always_comb begin
    if (host_addr == ADDR_W'(CTRL_ADDR)) begin
      win = WIN_CTRL;
    end else if ((host_addr >= ADDR_W'(TX_BASE)) && (tx_off < ADDR_W'(TX_BYTES))) begin
      win = WIN_TX;
    end else if ((host_addr >= ADDR_W'(RX_BASE)) && (rx_off < ADDR_W'(RX_BYTES))) begin
      win = WIN_RX;
    end else begin
      win = WIN_NONE;
    end
  end

  assign tx_wr    = host_we && (win == WIN_TX);
  assign ctrl_wr  = host_we && (win == WIN_CTRL);
  assign tx_start = ctrl_wr && host_wdata[REQ_BIT];
  assign rx_pop   = ctrl_wr && host_wdata[POP_BIT];
  assign ovf_clr  = ctrl_wr && host_wdata[OVF_BIT];

  mbox_tx_buf #(
    .DATA_W     (DATA_W),
    .CELL_BYTES (TX_BYTES)
  ) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tx_wr),
    .wr_idx    (tx_off[TX_IDX_W-1:0]),
    .wr_data   (host_wdata),
    .start     (tx_start),
    .busy      (tx_busy),
    .out_valid (cout_valid),
    .out_ready (cout_ready),
    .out_data  (cout_data),
    .out_last  (cout_last)
  );

  mbox_rx_fifo #(
    .DATA_W     (DATA_W),
    .CELL_BYTES (RX_BYTES),
    .CELLS      (RX_CELLS)
  ) u_rx (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (cin_valid),
    .in_data   (cin_data),
    .pop       (rx_pop),
    .rd_idx    (rx_off[RX_IDX_W-1:0]),
    .rd_data   (rx_rd_data),
    .not_empty (rx_not_empty),
    .drop      (rx_drop)
  );

  // sticky overflow: a new drop wins over a clear in the same cycle
  always_comb begin
    ovf_d = ovf_q;
    if (rx_drop) begin
      ovf_d = 1'b1;
    end else if (ovf_clr) begin
      ovf_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= ovf_d;
    end
  end

  // read mux
  always_comb begin
    host_rdata = '0;
    case (win)
      WIN_CTRL: begin
        host_rdata[REQ_BIT] = tx_busy;
        host_rdata[POP_BIT] = rx_not_empty;
        host_rdata[OVF_BIT] = ovf_q;
      end
      WIN_RX:   host_rdata = rx_rd_data;
      default:  host_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ctl_mbox_chk.sv
module ctl_mbox_chk #(
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned CTRL_ADDR = 'h10,
  parameter int unsigned RX_BASE   = 'h60,
  parameter int unsigned RX_BYTES  = 52
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] host_addr,
  input logic [DATA_W-1:0] host_rdata,
  input logic              cout_valid,
  input logic              cout_ready,
  input logic [DATA_W-1:0] cout_data,
  input logic              cout_last,
  input logic              tx_busy,
  input logic              rx_not_empty,
  input logic              ovf_q,
  input logic              ovf_clr
);

  logic in_rx;
  assign in_rx = (32'(host_addr) >= RX_BASE) && (32'(host_addr) < RX_BASE + RX_BYTES);

  assert_last_with_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cout_last |-> cout_valid);

  assert_stall_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cout_valid && !cout_ready) |=> (cout_valid && $stable(cout_data) && $stable(cout_last)));

  assert_busy_ends_on_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> $past(cout_valid && cout_ready && cout_last));

  assert_status_tracks_tx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(host_addr) == CTRL_ADDR) |-> (host_rdata[0] == cout_valid));

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_q && !ovf_clr) |=> ovf_q);

  assert_empty_reads_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_not_empty && in_rx) |-> (host_rdata == '0));

endmodule

bind ctl_mbox ctl_mbox_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .CTRL_ADDR (CTRL_ADDR),
  .RX_BASE   (RX_BASE),
  .RX_BYTES  (RX_BYTES)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .host_addr    (host_addr),
  .host_rdata   (host_rdata),
  .cout_valid   (cout_valid),
  .cout_ready   (cout_ready),
  .cout_data    (cout_data),
  .cout_last    (cout_last),
  .tx_busy      (tx_busy),
  .rx_not_empty (rx_not_empty),
  .ovf_q        (ovf_q),
  .ovf_clr      (ovf_clr)
);

// File: tb/ctl_mbox_tb_top.sv
module ctl_mbox_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TXB  = 56;
  localparam int RXB  = 52;
  localparam int CAP  = 4;
  localparam logic [7:0] CTRL = 8'h10;
  localparam logic [7:0] TXA  = 8'hA0;
  localparam logic [7:0] RXA  = 8'h60;

  logic       clk;
  logic       arst_n;
  logic       host_we;
  logic [7:0] host_addr;
  logic [7:0] host_wdata;
  logic [7:0] host_rdata;
  logic       cin_valid;
  logic [7:0] cin_data;
  logic       cout_valid;
  logic       cout_ready;
  logic [7:0] cout_data;
  logic       cout_last;

  int checks;
  int errors;
  bit finished;

  logic [7:0] exp_tx [TXB];
  logic [7:0] mdl [8][RXB];
  int mhead;
  int mtail;
  int mcnt;

  ctl_mbox dut_i (
    .clk        (clk),
    .arst_n     (arst_n),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .cin_valid  (cin_valid),
    .cin_data   (cin_data),
    .cout_valid (cout_valid),
    .cout_ready (cout_ready),
    .cout_data  (cout_data),
    .cout_last  (cout_last)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    host_we    = 1'b1;
    host_addr  = a;
    host_wdata = d;
    @(negedge clk);
    host_we    = 1'b0;
    host_addr  = CTRL;
  endtask

  task automatic hread(input logic [7:0] a, output logic [7:0] v);
    @(negedge clk);
    host_we   = 1'b0;
    host_addr = a;
    #1 v = host_rdata;
  endtask

  task automatic load_tx();
    for (int k = 0; k < TXB; k++) begin
      exp_tx[k] = 8'($urandom);
      hwrite(8'(TXA + k), exp_tx[k]);
    end
  endtask

  // request a send and collect it; optionally try to overwrite the buffer first
  task automatic run_tx(input bit junk);
    logic [7:0] v;
    logic [7:0] got [TXB];
    bit         lastf [TXB];
    int         n;
    bit         stall;
    logic [7:0] sdata;
    int         guard;
    cout_ready = 1'b0;
    hwrite(CTRL, 8'h01);
    if (junk) begin
      for (int k = 0; k < 8; k++) hwrite(8'(TXA + k * 7), ~exp_tx[k * 7]);
    end
    hread(CTRL, v);
    chk(v[0] == 1'b1, "R4 busy after request", int'(v), 1);
    n = 0; stall = 0; sdata = '0; guard = 0;
    while (n < TXB && guard < 2000) begin
      guard++;
      @(negedge clk);
      host_addr  = CTRL;
      cout_ready = ($urandom % 3) != 0;
      #1;
      if (stall) chk(cout_valid && cout_data == sdata, "R3 hold under stall", int'(cout_data), int'(sdata));
      stall = cout_valid && !cout_ready;
      sdata = cout_data;
      if (cout_valid && cout_ready) begin
        got[n]   = cout_data;
        lastf[n] = cout_last;
        if (n < TXB - 1) chk(host_rdata[0] == 1'b1, "R4 busy mid cell", int'(host_rdata), 1);
        n++;
      end
    end
    @(negedge clk);
    cout_ready = 1'b0;
    #1;
    chk(host_rdata[0] == 1'b0 && !cout_valid, "R4 clear after last", int'(host_rdata), 0);
    chk(n == TXB, "R2 byte count", n, TXB);
    for (int k = 0; k < n; k++) begin
      chk(got[k] == exp_tx[k], junk ? "R5 buffer kept" : "R2 byte order", int'(got[k]), int'(exp_tx[k]));
      chk(lastf[k] == (k == TXB - 1), "R2 last marker", int'(lastf[k]), int'(k == TXB - 1));
    end
  endtask

  task automatic push_cell();
    logic [7:0] b [RXB];
    for (int k = 0; k < RXB; k++) b[k] = 8'($urandom);
    if (mcnt < CAP) begin
      for (int k = 0; k < RXB; k++) mdl[mtail % 8][k] = b[k];
      mtail++;
      mcnt++;
    end
    for (int k = 0; k < RXB; k++) begin
      while (($urandom % 4) == 0) begin
        @(negedge clk);
        cin_valid = 1'b0;
      end
      @(negedge clk);
      cin_valid = 1'b1;
      cin_data  = b[k];
    end
    @(negedge clk);
    cin_valid = 1'b0;
  endtask

  task automatic check_head();
    logic [7:0] v;
    int bad;
    int first_bad_act;
    int first_bad_exp;
    bad = 0; first_bad_act = 0; first_bad_exp = 0;
    for (int k = 0; k < RXB; k++) begin
      hread(8'(RXA + k), v);
      if (v != mdl[mhead % 8][k] && bad == 0) begin
        first_bad_act = int'(v);
        first_bad_exp = int'(mdl[mhead % 8][k]);
      end
      if (v != mdl[mhead % 8][k]) bad++;
    end
    chk(bad == 0, "R6 head cell bytes", first_bad_act, first_bad_exp);
  endtask

  task automatic pop_head();
    hwrite(CTRL, 8'h02);
    if (mcnt > 0) begin
      mhead++;
      mcnt--;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    checks = 0; errors = 0; finished = 0;
    mhead = 0; mtail = 0; mcnt = 0;
    void'($urandom(32'd20240611));
    arst_n = 1'b0; host_we = 1'b0; host_addr = CTRL; host_wdata = '0;
    cin_valid = 1'b0; cin_data = '0; cout_ready = 1'b0;
    repeat (4) @(negedge clk);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    hread(CTRL, v);
    chk(v == 8'h00, "R1 status after reset", int'(v), 0);
    chk(!cout_valid, "R1 cout_valid after reset", int'(cout_valid), 0);

    // R9 empty window and unmapped offsets
    hread(RXA, v);
    chk(v == 8'h00, "R9 empty window low", int'(v), 0);
    hread(8'h93, v);
    chk(v == 8'h00, "R9 empty window high", int'(v), 0);

    // R2/R3/R4 transmit with random data and stalls
    load_tx();
    run_tx(1'b0);
    load_tx();
    run_tx(1'b1);
    // R5 resend without reload
    run_tx(1'b0);

    // R6/R7 receive queue
    push_cell();
    push_cell();
    push_cell();
    hread(CTRL, v);
    chk(v[1] == 1'b1, "R9 non-empty bit", int'(v), 2);
    check_head();
    pop_head();
    check_head();
    push_cell();
    push_cell();
    hread(CTRL, v);
    chk(v[2] == 1'b0, "R8 no overflow at capacity", int'(v), 2);
    // boundary offsets while queue holds cells
    hread(8'h94, v);
    chk(v == 8'h00, "R9 past window reads zero", int'(v), 0);
    hread(8'h5F, v);
    chk(v == 8'h00, "R9 below window reads zero", int'(v), 0);
    hread(8'h93, v);
    chk(v == mdl[mhead % 8][RXB - 1], "R6 last byte offset", int'(v), int'(mdl[mhead % 8][RXB - 1]));
    // fifth cell while full: dropped
    push_cell();
    hread(CTRL, v);
    chk(v[2] == 1'b1, "R8 overflow set", int'(v), 4);
    repeat (10) @(negedge clk);
    hread(CTRL, v);
    chk(v[2] == 1'b1, "R8 overflow sticky", int'(v), 4);
    for (int c = 0; c < CAP; c++) begin
      check_head();
      pop_head();
    end
    hread(CTRL, v);
    chk(v[1] == 1'b0, "R7 empty after draining, dropped cell absent", int'(v), 0);
    hread(8'(RXA + 5), v);
    chk(v == 8'h00, "R9 drained window zero", int'(v), 0);
    hwrite(CTRL, 8'h04);
    hread(CTRL, v);
    chk(v == 8'h00, "R8 overflow cleared", int'(v), 0);
    // pop on empty has no effect
    pop_head();
    hread(CTRL, v);
    chk(v == 8'h00, "R7 pop on empty ignored", int'(v), 0);
    push_cell();
    check_head();
    hread(CTRL, v);
    chk(v == 8'h02, "R7 single cell after empty pop", int'(v), 2);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule